// File: doc/BRIEF.md
# Handshake control line generator

This block produces the levels of the two outgoing control lines of a parallel port, CA2 (port A side) and CB2 (port B side), from an 8-bit peripheral control register value and a few port events. Each line has a three-bit mode field in the control register. The field selects one of four behaviours: a steady level, a handshake, a one-clock pulse, or input mode. In input mode the line is not driven by this block and reads as logic high.

In handshake mode the line rises to mean "not ready" on a synchronised edge pulse from its companion input: CA1 for CA2, CB1 for CB2. No processor action is needed for this. The line falls again, meaning "ready", when the processor accesses the matching port data register. Port A counts both reads and writes. Port B counts only writes. Pulse mode drives the line low for one clock after the same kind of access.

The control register value and the access strobes come from the register file around the block. The edge pulses come from the input synchroniser and edge detector of the port.

Top module: `hsLineGen`

## Requirements
- R1: After reset both outputs are high. A line switched into handshake mode before any port access presents high (not ready).
- R2: A mode field with its top bit 0 (codes 000 to 011, input mode) gives a high output, whatever events arrive.
- R3: Mode code 110 drives the line low and 111 drives it high, in the same cycle as the control value, and events have no effect. The CB2 mode field is control bits 7..5. The CA2 mode field is control bits 3..1.
- R4: Control bits 0 and 4 have no effect on either output.
- R5: In CA2 handshake mode (code 100), a ca1Edge pulse sampled at a rising clock edge makes ca2Out high right after that edge.
- R6: In CA2 handshake mode, a port A access, read or write (portASel high), makes ca2Out low right after the sampling edge. The low level holds until the next ca1Edge.
- R7: In CB2 handshake mode (code 100), a port B write (portBSel and portWrite high) makes cb2Out low right after the sampling edge, and a cb1Edge pulse makes it high.
- R8: In CB2 handshake mode, a port B read (portBSel high, portWrite low) leaves cb2Out unchanged.
- R9: In pulse mode (code 101), the line is low for exactly the one clock after each qualifying access and high otherwise. A port A read or write qualifies for CA2. Only a port B write qualifies for CB2.
- R10: When a raising edge pulse and a lowering access arrive in the same cycle in handshake mode, the line goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlReg | input | 8 | Peripheral control register value |
| ca1Edge | input | 1 | One-cycle pulse for an active CA1 edge |
| cb1Edge | input | 1 | One-cycle pulse for an active CB1 edge |
| portASel | input | 1 | Port A data register access strobe |
| portBSel | input | 1 | Port B data register access strobe |
| portWrite | input | 1 | Direction of the access, 1 for write |
| ca2Out | output | 1 | CA2 line level |
| cb2Out | output | 1 | CB2 line level |

## Verification
Steady and input-mode levels follow ctrlReg in the same cycle. Handshake and pulse results are due one clock after the edge that samples the event or access. Each stimulus step is applied at a falling edge. The expected levels for that step are queued with it and compared 2 ns after the next rising edge, so one register stage is covered exactly. The pulse checks use consecutive steps, so the single low clock and the return to high are both observed at their own cycles.

// File: rtl/hsLinePkg.sv
package hsLinePkg;
  localparam int NUM_LINES = 2;
  localparam int CTRL_W = 8;
  localparam int MODE_W = 3;
  localparam int LINE_A = 0;
  localparam int LINE_B = 1;
  localparam int FIELD_LSB_A = 1;
  localparam int FIELD_LSB_B = 5;

  typedef logic [MODE_W-1:0] modeT;
  localparam modeT MODE_HS    = 3'b100;
  localparam modeT MODE_PULSE = 3'b101;
  localparam modeT MODE_LOW   = 3'b110;
  localparam modeT MODE_HIGH  = 3'b111;

  typedef struct packed {
    logic setEv;
    logic clrEv;
    logic pulseEv;
  } lineStrobeT;
endpackage

// File: rtl/hsCtrl.sv
module hsCtrl
  import hsLinePkg::*;
(
  input  logic [CTRL_W-1:0]                 ctrlReg,
  input  logic                              ca1Edge,
  input  logic                              cb1Edge,
  input  logic                              portASel,
  input  logic                              portBSel,
  input  logic                              portWrite,
  output modeT       [NUM_LINES-1:0]        lineMode,
  output lineStrobeT [NUM_LINES-1:0]        strobe
);
  logic [NUM_LINES-1:0] raiseSrc;
  logic [NUM_LINES-1:0] accessSrc;
  logic unusedEdgeSel;

  assign unusedEdgeSel = ^{ctrlReg[0], ctrlReg[4]};

  assign raiseSrc[LINE_A]  = ca1Edge;
  assign raiseSrc[LINE_B]  = cb1Edge;
  assign accessSrc[LINE_A] = portASel;
  assign accessSrc[LINE_B] = portBSel & portWrite;

  for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
    localparam int FLSB = (i == LINE_A) ? FIELD_LSB_A : FIELD_LSB_B;
    assign lineMode[i] = ctrlReg[FLSB +: MODE_W];
    always_comb begin
      strobe[i].setEv   = raiseSrc[i]  && (lineMode[i] == MODE_HS);
      strobe[i].clrEv   = accessSrc[i] && (lineMode[i] == MODE_HS);
      strobe[i].pulseEv = accessSrc[i] && (lineMode[i] == MODE_PULSE);
    end
  end
endmodule

// File: rtl/hsDatapath.sv
module hsDatapath
  import hsLinePkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  modeT       [NUM_LINES-1:0]        lineMode,
  input  lineStrobeT [NUM_LINES-1:0]        strobe,
  output logic       [NUM_LINES-1:0]        lineOut
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
    logic notReady;
    logic pulseLow;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        notReady <= 1'b1;
        pulseLow <= 1'b0;
      end else begin
        if (strobe[i].setEv)      notReady <= 1'b1;
        else if (strobe[i].clrEv) notReady <= 1'b0;
        pulseLow <= strobe[i].pulseEv;
      end
    end

    always_comb begin
      case (lineMode[i])
        MODE_HS:    lineOut[i] = notReady;
        MODE_PULSE: lineOut[i] = ~pulseLow;
        MODE_LOW:   lineOut[i] = 1'b0;
        default:    lineOut[i] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/hsLineGen.sv
module hsLineGen
  import hsLinePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        ctrlReg,
  input  logic              ca1Edge,
  input  logic              cb1Edge,
  input  logic              portASel,
  input  logic              portBSel,
  input  logic              portWrite,
  output logic              ca2Out,
  output logic              cb2Out
);
  modeT       [NUM_LINES-1:0] lineMode;
  lineStrobeT [NUM_LINES-1:0] strobe;
  logic       [NUM_LINES-1:0] lineOut;

  hsCtrl uCtrl (
    .ctrlReg   (ctrlReg),
    .ca1Edge   (ca1Edge),
    .cb1Edge   (cb1Edge),
    .portASel  (portASel),
    .portBSel  (portBSel),
    .portWrite (portWrite),
    .lineMode  (lineMode),
    .strobe    (strobe)
  );

  hsDatapath uData (
    .clk      (clk),
    .rstN     (rstN),
    .lineMode (lineMode),
    .strobe   (strobe),
    .lineOut  (lineOut)
  );

  assign ca2Out = lineOut[LINE_A];
  assign cb2Out = lineOut[LINE_B];
endmodule

// File: rtl/hsLineGenChk.sv
module hsLineGenChk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] ctrlReg,
  input logic       ca1Edge,
  input logic       cb1Edge,
  input logic       portASel,
  input logic       portBSel,
  input logic       portWrite,
  input logic       ca2Out,
  input logic       cb2Out
);
  AST_INPUT_MODE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[3] |-> ca2Out) and (!ctrlReg[7] |-> cb2Out)); // R2
  AST_MANUAL_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[7:6] == 2'b11) |-> (cb2Out == ctrlReg[5])); // R3
  AST_CA2_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[3:1] == 3'b100 && ca1Edge) |=> (ctrlReg[3:1] != 3'b100 || ca2Out)); // R5
  AST_CA2_LOWER: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[3:1] == 3'b100 && portASel && !ca1Edge) |=> (ctrlReg[3:1] != 3'b100 || !ca2Out)); // R6
  AST_CB2_READ_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[7:5] == 3'b100 && portBSel && !portWrite && !cb1Edge)
      |=> (ctrlReg[7:5] != 3'b100 || cb2Out == $past(cb2Out))); // R8
  AST_PULSE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[3:1] == 3'b101 && !portASel) |=> (ctrlReg[3:1] != 3'b101 || ca2Out)); // R9
endmodule

bind hsLineGen hsLineGenChk uChk (.*);

// File: tb/tb_hsLineGen.sv
module tb_hsLineGen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] ctrlReg = 8'h00;
  logic       ca1Edge = 1'b0;
  logic       cb1Edge = 1'b0;
  logic       portASel = 1'b0;
  logic       portBSel = 1'b0;
  logic       portWrite = 1'b0;
  logic       ca2Out;
  logic       cb2Out;

  typedef struct {
    logic  ca2;
    logic  cb2;
    string tag;
  } expItemT;

  expItemT expQ[$];
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hsLineGen dut (.*);

  task automatic step(input logic [7:0] c, input logic a1, input logic b1,
                      input logic aSel, input logic bSel, input logic wr,
                      input logic expA, input logic expB, input string tag);
    expItemT it;
    @(negedge clk);
    ctrlReg = c; ca1Edge = a1; cb1Edge = b1;
    portASel = aSel; portBSel = bSel; portWrite = wr;
    it.ca2 = expA; it.cb2 = expB; it.tag = tag;
    expQ.push_back(it);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItemT it;
        it = expQ.pop_front();
        checks++;
        if (ca2Out !== it.ca2 || cb2Out !== it.cb2) begin
          fails++;
          $display("FAIL %s: ca2Out/cb2Out actual %b/%b expected %b/%b",
                   it.tag, ca2Out, cb2Out, it.ca2, it.cb2);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state and initial handshake level
    step(8'h00, 0,0,0,0,0, 1,1, "R1");
    step(8'h88, 0,0,0,0,0, 1,1, "R1");
    // R6 port A read then hold
    step(8'h88, 0,0,1,0,0, 0,1, "R6");
    step(8'h88, 0,0,0,0,0, 0,1, "R6");
    // R5 CA1 edge raises
    step(8'h88, 1,0,0,0,0, 1,1, "R5");
    // R6 port A write lowers
    step(8'h88, 0,0,1,0,1, 0,1, "R6");
    // R8 port B read ignored
    step(8'h88, 0,0,0,1,0, 0,1, "R8");
    // R7 port B write lowers, CB1 edge raises
    step(8'h88, 0,0,0,1,1, 0,0, "R7");
    step(8'h88, 0,0,0,0,0, 0,0, "R7");
    step(8'h88, 0,1,0,0,0, 0,1, "R7");
    // R10 edge and access together
    step(8'h88, 0,0,1,1,1, 0,0, "R10");
    step(8'h88, 1,1,1,1,1, 1,1, "R10");
    // R4 bits 0 and 4 have no effect
    step(8'h99, 0,0,0,0,0, 1,1, "R4");
    // R3 steady levels, both fields
    step(8'hEC, 0,0,0,0,0, 0,1, "R3");
    step(8'hCE, 0,0,0,0,0, 1,0, "R3");
    step(8'hDF, 0,0,0,0,0, 1,0, "R4");
    step(8'hEC, 1,1,1,1,1, 0,1, "R3");
    // R2 input mode
    step(8'h00, 1,1,1,1,1, 1,1, "R2");
    step(8'h66, 1,1,1,1,0, 1,1, "R2");
    // R9 pulse mode
    step(8'hAA, 0,0,0,0,0, 1,1, "R9");
    step(8'hAA, 0,0,1,0,0, 0,1, "R9");
    step(8'hAA, 0,0,0,0,0, 1,1, "R9");
    step(8'hAA, 0,0,0,1,0, 1,1, "R9");
    step(8'hAA, 0,0,0,1,1, 1,0, "R9");
    step(8'hAA, 0,0,0,0,0, 1,1, "R9");
    step(8'hAA, 0,0,1,0,1, 0,1, "R9");
    step(8'hAA, 0,0,1,0,1, 0,1, "R9");
    step(8'hAA, 0,0,0,0,0, 1,1, "R9");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule